// File: doc/BRIEF.md
# DRAM Column Command Timing Tracker

This block keeps, for every bank of a multi-rank DRAM channel with bank groups, how many cycles remain before a read column command, a write column command, a precharge or an activate may be sent to that bank. It also keeps the channel-wide wait before the next data burst may start. A scheduler shows the tracker the column command it is about to send. The tracker answers with the cycle offset at which that command will issue and the offset at which its data will be ready. When the command is sent, the tracker raises the limits of every bank in the channel. The new limits depend on the command type and on where each bank sits relative to the command: the same bank group, another group of the same rank, or another rank.

Turnaround between reads and writes is charged to the per-bank read and write limits and not to a separate bus bubble. For this reason a bank may accept a read long before it may accept a write, or the other way round. A row activation raises the bank's column limits by the row-to-column delay and its precharge limit by the minimum row-active time. A rank leaving a low-power state raises all four limits of each of its banks by an exit delay given at the port. A query port reports, for any bank and command type, the remaining wait and whether the command may go in the current cycle.

Every value is a count of cycles relative to the current cycle. A limit reported as W in cycle t means the command may issue in cycle t+W. Every limit counts down by one per cycle and stops at zero.

Top module: `dram_col_timer`

## Requirements
- R1: While reset is held, every per-bank limit is zero and the next-burst wait equals T_RP+T_RCD (20 with defaults). So a read query reports qry_wait=20 and qry_ok=0, col_issue_in=20, col_data_in=35, and the precharge and activate waits are 0.
- R2: For the presented column command, col_issue_in is the larger of two values: the bank's limit for that command type and the next-burst wait. col_data_in equals col_issue_in+T_CL+T_BURST. After the command is issued, the next-burst wait is the issue offset plus T_BURST.
- R3: After a column command issued at offset I, a bank of the same rank and the same bank group gets new limits, reported one cycle later as I+D-1. After a read, D is T_CCD_L for the next read and max(T_CCD_L, T_RTW+T_BURST) for the next write. After a write, D is max(T_CCD_L, T_CL+T_BURST+T_WTR) for the next read and T_CCD_L_WR for the next write. A bank's group is its index divided by BANKS_PER_RANK/BANK_GROUPS, so banks 0 and 1 share group 0 and bank 2 is in group 1 with defaults.
- R4: For a bank of the same rank in another group, D is as follows. After a read: T_BURST for the next read, T_RTW+T_BURST for the next write. After a write: T_CL+T_BURST+T_WTR for the next read, T_BURST for the next write. With a single bank group, every bank of the rank uses these values.
- R5: For a bank of any other rank, D is T_CS+T_BURST for both the next read and the next write.
- R6: An update never lowers a limit. Each new limit is the larger of the decremented old limit and the value the event requests.
- R7: A row activation of one bank raises that bank's read and write limits to at least T_RCD-1 and its precharge limit to at least T_RAS-1, all read in the next cycle. Other banks are not touched.
- R8: A wake of one rank with exit delay E raises the read, write, precharge and activate limits of each bank of that rank to at least E-1 in the next cycle. Other ranks are untouched.
- R9: Each limit decreases by one per cycle down to zero. qry_wait is the larger of the queried limit and the next-burst wait. qry_ok is 1 exactly when qry_wait is 0.
- R10: A column command, an activation and a wake in the same cycle all take effect, and each limit ends at the largest of the values they request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_valid | input | 1 | Column command is sent this cycle |
| col_is_wr | input | 1 | Column command type: 1 write, 0 read |
| col_rank | input | RANK_W | Rank of the column command |
| col_bank | input | BANK_W | Bank within the rank of the column command |
| col_issue_in | output | CNT_W | Cycles until the presented column command issues |
| col_data_in | output | CNT_W+1 | Cycles until its data is ready |
| act_valid | input | 1 | Row activation this cycle |
| act_rank | input | RANK_W | Rank of the activation |
| act_bank | input | BANK_W | Bank of the activation |
| wake_valid | input | 1 | Rank leaves low power this cycle |
| wake_rank | input | RANK_W | Rank that wakes |
| wake_exit | input | CNT_W | Exit delay in cycles |
| qry_is_wr | input | 1 | Query type: 1 write, 0 read |
| qry_rank | input | RANK_W | Queried rank |
| qry_bank | input | BANK_W | Queried bank |
| qry_ok | output | 1 | Queried command may issue this cycle |
| qry_wait | output | CNT_W | Cycles until the queried command may issue |
| qry_pre_wait | output | CNT_W | Cycles until the queried bank may precharge |
| qry_act_wait | output | CNT_W | Cycles until the queried bank may activate |

## Verification
A column command, a row activation and a rank wake can land in the same cycle on the same rank. Each of them then asks for a different floor on the same registers. The bench sends a read to bank 0 of rank 1, activates bank 5 of rank 1 and wakes rank 1 with exit delay 5, all in one cycle. The delays are picked so that a different source wins on each bank. In the next cycle it checks four results against the largest of the requested values: bank 1's write limit is set by the column command (7), bank 5's read limit by the activation (9), bank 5's activate limit by the wake (4), and bank 4's read wait by the wake rather than the burst (4).

// File: rtl/dct_pkg.sv
package dct_pkg;

    // Position of a bank relative to the column command just issued
    typedef enum logic [1:0] {
        REL_SAME_GRP   = 2'd0,
        REL_OTHER_GRP  = 2'd1,
        REL_OTHER_RANK = 2'd2
    } rel_e;

endpackage

// File: rtl/dct_gap_sel.sv
module dct_gap_sel
    import dct_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int T_BURST    = 4,
    parameter int T_CCD_L    = 6,
    parameter int T_CCD_L_WR = 6,
    parameter int T_CL       = 11,
    parameter int T_WTR      = 3,
    parameter int T_RTW      = 4,
    parameter int T_CS       = 2
) (
    input  logic             src_is_wr,
    input  rel_e             rel,
    output logic [CNT_W-1:0] gap_rd,
    output logic [CNT_W-1:0] gap_wr
);
    localparam int RD_TO_WR = T_RTW + T_BURST;
    localparam int WR_TO_RD = T_CL + T_BURST + T_WTR;
    localparam int RANK_SW  = T_CS + T_BURST;
    localparam int SG_RD_WR = (T_CCD_L > RD_TO_WR) ? T_CCD_L : RD_TO_WR;
    localparam int SG_WR_RD = (T_CCD_L > WR_TO_RD) ? T_CCD_L : WR_TO_RD;

    always_comb begin
        case (rel)
            REL_SAME_GRP: begin
                gap_rd = src_is_wr ? CNT_W'(SG_WR_RD)   : CNT_W'(T_CCD_L);
                gap_wr = src_is_wr ? CNT_W'(T_CCD_L_WR) : CNT_W'(SG_RD_WR);
            end
            REL_OTHER_GRP: begin
                gap_rd = src_is_wr ? CNT_W'(WR_TO_RD) : CNT_W'(T_BURST);
                gap_wr = src_is_wr ? CNT_W'(T_BURST)  : CNT_W'(RD_TO_WR);
            end
            default: begin
                gap_rd = CNT_W'(RANK_SW);
                gap_wr = CNT_W'(RANK_SW);
            end
        endcase
    end

endmodule

// File: rtl/dct_bank_timer.sv
module dct_bank_timer
    import dct_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int T_BURST    = 4,
    parameter int T_CCD_L    = 6,
    parameter int T_CCD_L_WR = 6,
    parameter int T_CL       = 11,
    parameter int T_WTR      = 3,
    parameter int T_RTW      = 4,
    parameter int T_CS       = 2,
    parameter int T_RCD      = 10,
    parameter int T_RAS      = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             col_fire,
    input  logic             col_is_wr,
    input  rel_e             col_rel,
    input  logic [CNT_W-1:0] col_start,
    input  logic             act_hit,
    input  logic             wake_hit,
    input  logic [CNT_W-1:0] wake_exit,
    output logic [CNT_W-1:0] rd_wait,
    output logic [CNT_W-1:0] wr_wait,
    output logic [CNT_W-1:0] pre_wait,
    output logic [CNT_W-1:0] act_wait
);
    localparam int              WIDE_W = CNT_W + 2;
    localparam logic [WIDE_W-1:0] CAP  = WIDE_W'((1 << CNT_W) - 1);

    typedef struct packed {
        logic [CNT_W-1:0] rd;
        logic [CNT_W-1:0] wr;
        logic [CNT_W-1:0] pre;
        logic [CNT_W-1:0] act;
    } lim_t;

    lim_t st_d, st_q;
    logic [CNT_W-1:0] gap_rd, gap_wr;

    dct_gap_sel #(
        .CNT_W(CNT_W), .T_BURST(T_BURST), .T_CCD_L(T_CCD_L),
        .T_CCD_L_WR(T_CCD_L_WR), .T_CL(T_CL), .T_WTR(T_WTR),
        .T_RTW(T_RTW), .T_CS(T_CS)
    ) u_gap (
        .src_is_wr(col_is_wr),
        .rel      (col_rel),
        .gap_rd   (gap_rd),
        .gap_wr   (gap_wr)
    );

    // Offset from now turned into the count held in the next cycle
    function automatic logic [CNT_W-1:0] lift(input logic [WIDE_W-1:0] tgt);
        if (tgt == '0) return '0;
        if (tgt - WIDE_W'(1) > CAP) return CAP[CNT_W-1:0];
        return CNT_W'(tgt - WIDE_W'(1));
    endfunction

    function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v);
        return (v == '0) ? '0 : v - CNT_W'(1);
    endfunction

    function automatic logic [CNT_W-1:0] hi(input logic [CNT_W-1:0] a,
                                            input logic [CNT_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    always_comb begin
        st_d.rd  = step(st_q.rd);
        st_d.wr  = step(st_q.wr);
        st_d.pre = step(st_q.pre);
        st_d.act = step(st_q.act);
        if (col_fire) begin
            st_d.rd = hi(st_d.rd, lift(WIDE_W'(col_start) + WIDE_W'(gap_rd)));
            st_d.wr = hi(st_d.wr, lift(WIDE_W'(col_start) + WIDE_W'(gap_wr)));
        end
        if (act_hit) begin
            st_d.rd  = hi(st_d.rd,  lift(WIDE_W'(T_RCD)));
            st_d.wr  = hi(st_d.wr,  lift(WIDE_W'(T_RCD)));
            st_d.pre = hi(st_d.pre, lift(WIDE_W'(T_RAS)));
        end
        if (wake_hit) begin
            st_d.rd  = hi(st_d.rd,  lift(WIDE_W'(wake_exit)));
            st_d.wr  = hi(st_d.wr,  lift(WIDE_W'(wake_exit)));
            st_d.pre = hi(st_d.pre, lift(WIDE_W'(wake_exit)));
            st_d.act = hi(st_d.act, lift(WIDE_W'(wake_exit)));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_wait  = st_q.rd;
    assign wr_wait  = st_q.wr;
    assign pre_wait = st_q.pre;
    assign act_wait = st_q.act;

    // R6
    rd_never_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rd_wait + CNT_W'(1) >= $past(rd_wait)));

    // R6
    wr_never_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (wr_wait + CNT_W'(1) >= $past(wr_wait)));

    // R7
    act_rcd_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_hit |=> (rd_wait >= CNT_W'(T_RCD - 1)) && (wr_wait >= CNT_W'(T_RCD - 1))
                    && (pre_wait >= CNT_W'(T_RAS - 1)));

    // R8
    wake_exit_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_hit && wake_exit != '0) |=> (act_wait + CNT_W'(1) >= $past(wake_exit))
                                          && (rd_wait + CNT_W'(1) >= $past(wake_exit)));

    // R9
    act_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_hit && act_wait != '0) |=> (act_wait == $past(act_wait) - CNT_W'(1)));

endmodule

// File: rtl/dct_burst_timer.sv
module dct_burst_timer #(
    parameter int CNT_W   = 8,
    parameter int T_BURST = 4,
    parameter int T_INIT  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_fire,
    input  logic [CNT_W-1:0] issue_at,
    output logic [CNT_W-1:0] burst_wait
);
    localparam int                WIDE_W = CNT_W + 2;
    localparam logic [WIDE_W-1:0] CAP    = WIDE_W'((1 << CNT_W) - 1);

    typedef struct packed {
        logic [CNT_W-1:0] gap;
    } bus_t;

    bus_t st_d, st_q;
    logic [WIDE_W-1:0] end_at;

    always_comb begin
        end_at = WIDE_W'(issue_at) + WIDE_W'(T_BURST) - WIDE_W'(1);
        st_d.gap = (st_q.gap == '0) ? '0 : st_q.gap - CNT_W'(1);
        if (issue_fire) begin
            st_d.gap = (end_at > CAP) ? CAP[CNT_W-1:0] : CNT_W'(end_at);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.gap <= CNT_W'(T_INIT);
        else        st_q     <= st_d;
    end

    assign burst_wait = st_q.gap;

    // R2
    burst_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_fire && issue_at < CNT_W'((1 << CNT_W) - 1 - T_BURST))
            |=> (burst_wait == $past(issue_at) + CNT_W'(T_BURST - 1)));

endmodule

// File: rtl/dram_col_timer.sv
module dram_col_timer
    import dct_pkg::*;
#(
    parameter int NUM_RANKS      = 2,
    parameter int BANKS_PER_RANK = 8,
    parameter int BANK_GROUPS    = 4,
    parameter int CNT_W          = 8,
    parameter int T_BURST        = 4,
    parameter int T_CCD_L        = 6,
    parameter int T_CCD_L_WR     = T_CCD_L,
    parameter int T_CL           = 11,
    parameter int T_WTR          = 3,
    parameter int T_RTW          = 4,
    parameter int T_CS           = 2,
    parameter int T_RCD          = 10,
    parameter int T_RAS          = 20,
    parameter int T_RP           = 10,
    localparam int RANK_W        = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    localparam int BANK_W        = (BANKS_PER_RANK > 1) ? $clog2(BANKS_PER_RANK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              col_valid,
    input  logic              col_is_wr,
    input  logic [RANK_W-1:0] col_rank,
    input  logic [BANK_W-1:0] col_bank,
    output logic [CNT_W-1:0]  col_issue_in,
    output logic [CNT_W:0]    col_data_in,
    input  logic              act_valid,
    input  logic [RANK_W-1:0] act_rank,
    input  logic [BANK_W-1:0] act_bank,
    input  logic              wake_valid,
    input  logic [RANK_W-1:0] wake_rank,
    input  logic [CNT_W-1:0]  wake_exit,
    input  logic              qry_is_wr,
    input  logic [RANK_W-1:0] qry_rank,
    input  logic [BANK_W-1:0] qry_bank,
    output logic              qry_ok,
    output logic [CNT_W-1:0]  qry_wait,
    output logic [CNT_W-1:0]  qry_pre_wait,
    output logic [CNT_W-1:0]  qry_act_wait
);
    localparam int NB    = NUM_RANKS * BANKS_PER_RANK;
    localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;
    localparam int BPG   = BANKS_PER_RANK / BANK_GROUPS;

    if (BANK_GROUPS > 1 && (T_CCD_L <= T_BURST || T_CCD_L_WR <= T_BURST)) begin : g_bad_gap
        $error("same-group column gaps must exceed the burst length");
    end
    if (BANKS_PER_RANK % BANK_GROUPS != 0) begin : g_bad_grp
        $error("banks per rank must divide evenly into bank groups");
    end

    logic [CNT_W-1:0]  rd_w   [NB];
    logic [CNT_W-1:0]  wr_w   [NB];
    logic [CNT_W-1:0]  pre_w  [NB];
    logic [CNT_W-1:0]  act_w  [NB];
    logic [CNT_W-1:0]  burst_wait;
    logic [BANK_W-1:0] col_grp;
    logic [IDX_W-1:0]  col_idx, qry_idx;
    logic [CNT_W-1:0]  col_lim, qry_lim;

    assign col_grp = col_bank / BANK_W'(BPG);
    assign col_idx = IDX_W'(col_rank) * IDX_W'(BANKS_PER_RANK) + IDX_W'(col_bank);
    assign qry_idx = IDX_W'(qry_rank) * IDX_W'(BANKS_PER_RANK) + IDX_W'(qry_bank);

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        for (genvar b = 0; b < BANKS_PER_RANK; b++) begin : g_bank
            localparam int IDX = r * BANKS_PER_RANK + b;
            rel_e rel;
            logic same_rank, same_grp, act_hit, wake_hit;

            assign same_rank = (col_rank == RANK_W'(r));
            assign same_grp  = (col_grp == BANK_W'(b / BPG));
            if (BANK_GROUPS > 1) begin : g_grp
                assign rel = !same_rank ? REL_OTHER_RANK :
                             same_grp   ? REL_SAME_GRP   : REL_OTHER_GRP;
            end else begin : g_flat
                assign rel = same_rank ? REL_OTHER_GRP : REL_OTHER_RANK;
            end
            assign act_hit  = act_valid && (act_rank == RANK_W'(r)) && (act_bank == BANK_W'(b));
            assign wake_hit = wake_valid && (wake_rank == RANK_W'(r));

            dct_bank_timer #(
                .CNT_W(CNT_W), .T_BURST(T_BURST), .T_CCD_L(T_CCD_L),
                .T_CCD_L_WR(T_CCD_L_WR), .T_CL(T_CL), .T_WTR(T_WTR),
                .T_RTW(T_RTW), .T_CS(T_CS), .T_RCD(T_RCD), .T_RAS(T_RAS)
            ) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .col_fire (col_valid),
                .col_is_wr(col_is_wr),
                .col_rel  (rel),
                .col_start(col_issue_in),
                .act_hit  (act_hit),
                .wake_hit (wake_hit),
                .wake_exit(wake_exit),
                .rd_wait  (rd_w[IDX]),
                .wr_wait  (wr_w[IDX]),
                .pre_wait (pre_w[IDX]),
                .act_wait (act_w[IDX])
            );
        end
    end

    dct_burst_timer #(
        .CNT_W(CNT_W), .T_BURST(T_BURST), .T_INIT(T_RP + T_RCD)
    ) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_fire(col_valid),
        .issue_at  (col_issue_in),
        .burst_wait(burst_wait)
    );

    always_comb begin
        col_lim      = col_is_wr ? wr_w[col_idx] : rd_w[col_idx];
        col_issue_in = (col_lim > burst_wait) ? col_lim : burst_wait;
        col_data_in  = {1'b0, col_issue_in} + (CNT_W + 1)'(T_CL + T_BURST);
        qry_lim      = qry_is_wr ? wr_w[qry_idx] : rd_w[qry_idx];
        qry_ok       = (qry_lim == '0) && (burst_wait == '0);
        qry_wait     = (qry_lim > burst_wait) ? qry_lim : burst_wait;
        qry_pre_wait = pre_w[qry_idx];
        qry_act_wait = act_w[qry_idx];
    end

    // R9
    qry_ok_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qry_ok |-> (qry_wait == '0));

    // R2
    issue_after_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid |-> (col_issue_in >= burst_wait));

endmodule

// File: tb/sim_dram_col_timer.sv
`timescale 1ns/1ps
module sim_dram_col_timer;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic col_valid = 0, col_is_wr = 0, act_valid = 0, wake_valid = 0, qry_is_wr = 0;
    logic [0:0] col_rank = 0, act_rank = 0, wake_rank = 0, qry_rank = 0;
    logic [2:0] col_bank = 0, act_bank = 0, qry_bank = 0;
    logic [CNT_W-1:0] wake_exit = 0;
    logic [CNT_W-1:0] col_issue_in, qry_wait, qry_pre_wait, qry_act_wait;
    logic [CNT_W:0] col_data_in;
    logic qry_ok;
    int checks = 0, failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dram_col_timer #(.T_CCD_L_WR(9)) u0 (
        .clk(clk), .rst_n(rst_n),
        .col_valid(col_valid), .col_is_wr(col_is_wr), .col_rank(col_rank), .col_bank(col_bank),
        .col_issue_in(col_issue_in), .col_data_in(col_data_in),
        .act_valid(act_valid), .act_rank(act_rank), .act_bank(act_bank),
        .wake_valid(wake_valid), .wake_rank(wake_rank), .wake_exit(wake_exit),
        .qry_is_wr(qry_is_wr), .qry_rank(qry_rank), .qry_bank(qry_bank),
        .qry_ok(qry_ok), .qry_wait(qry_wait), .qry_pre_wait(qry_pre_wait),
        .qry_act_wait(qry_act_wait)
    );

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    task automatic peek(logic wr, int r, int b);
        qry_is_wr = wr; qry_rank = 1'(r); qry_bank = 3'(b);
        #1;
    endtask

    task automatic drain();
        repeat (25) @(negedge clk);
    endtask

    task automatic set_col(logic wr, int r, int b);
        col_valid = 1; col_is_wr = wr; col_rank = 1'(r); col_bank = 3'(b);
    endtask

    task automatic t_reset();
        peek(0, 0, 0);
        set_col(0, 0, 0); col_valid = 0;
        #1;
        chk("R1 reset qry_wait", int'(qry_wait), 20);
        chk("R1 reset qry_ok", int'(qry_ok), 0);
        chk("R1 reset issue", int'(col_issue_in), 20);
        chk("R1 reset data", int'(col_data_in), 35);
        chk("R1 reset pre", int'(qry_pre_wait), 0);
        chk("R1 reset act", int'(qry_act_wait), 0);
        @(negedge clk); rst_n = 1;
        @(negedge clk); #1;
        chk("R9 countdown after reset", int'(qry_wait), 19);
    endtask

    task automatic gap_case(string tag, logic sw, int sr, int sb,
                            logic tw, int tr, int tb, int d);
        drain();
        set_col(sw, sr, sb);
        @(negedge clk); col_valid = 0;
        peek(tw, tr, tb);
        chk(tag, int'(qry_wait), d - 1);
    endtask

    task automatic t_gaps();
        gap_case("R3 rd->rd same grp", 0, 0, 0, 0, 0, 1, 6);
        gap_case("R3 rd->wr same grp", 0, 0, 0, 1, 0, 1, 8);
        gap_case("R3 wr->rd same grp", 1, 0, 0, 0, 0, 1, 18);
        gap_case("R3 wr->wr same grp", 1, 0, 0, 1, 0, 1, 9);
        gap_case("R3 rd->wr same bank", 0, 0, 0, 1, 0, 0, 8);
        gap_case("R4 rd->rd other grp", 0, 0, 0, 0, 0, 2, 4);
        gap_case("R4 rd->wr other grp", 0, 0, 0, 1, 0, 2, 8);
        gap_case("R4 wr->rd other grp", 1, 0, 0, 0, 0, 2, 18);
        gap_case("R4 wr->wr other grp", 1, 0, 0, 1, 0, 2, 4);
        gap_case("R5 rd other rank", 0, 0, 0, 0, 1, 0, 6);
        gap_case("R5 wr other rank", 1, 0, 5, 1, 1, 3, 6);
    endtask

    task automatic t_ready();
        drain();
        set_col(0, 0, 0);
        @(negedge clk); col_valid = 0;
        peek(0, 0, 1);
        chk("R9 wait after gap", int'(qry_wait), 5);
        repeat (4) @(negedge clk); #1;
        chk("R9 wait one", int'(qry_wait), 1);
        chk("R9 not ok at one", int'(qry_ok), 0);
        @(negedge clk); #1;
        chk("R9 wait zero", int'(qry_wait), 0);
        chk("R9 ok at zero", int'(qry_ok), 1);
    endtask

    task automatic t_no_early();
        drain();
        set_col(1, 0, 0);
        @(negedge clk);
        set_col(0, 1, 0);
        peek(0, 0, 1);
        chk("R2 issue offset", int'(col_issue_in), 5);
        chk("R2 data offset", int'(col_data_in), 20);
        chk("R3 wr->rd before", int'(qry_wait), 17);
        @(negedge clk); col_valid = 0;
        peek(0, 0, 1);
        chk("R6 limit kept", int'(qry_wait), 16);
        peek(1, 0, 0);
        chk("R6 other rank raises", int'(qry_wait), 10);
        peek(0, 1, 0);
        chk("R2 rd at offset raises", int'(qry_wait), 10);
    endtask

    task automatic t_activate();
        drain();
        act_valid = 1; act_rank = 0; act_bank = 3;
        @(negedge clk); act_valid = 0;
        peek(0, 0, 3);
        chk("R7 rd after act", int'(qry_wait), 9);
        chk("R7 pre after act", int'(qry_pre_wait), 19);
        chk("R7 act untouched", int'(qry_act_wait), 0);
        peek(1, 0, 3);
        chk("R7 wr after act", int'(qry_wait), 9);
        peek(0, 0, 2);
        chk("R7 other bank", int'(qry_wait), 0);
    endtask

    task automatic t_wake();
        drain();
        wake_valid = 1; wake_rank = 1; wake_exit = 7;
        @(negedge clk); wake_valid = 0;
        peek(0, 1, 6);
        chk("R8 rd after wake", int'(qry_wait), 6);
        chk("R8 pre after wake", int'(qry_pre_wait), 6);
        chk("R8 act after wake", int'(qry_act_wait), 6);
        peek(1, 1, 6);
        chk("R8 wr after wake", int'(qry_wait), 6);
        peek(0, 0, 6);
        chk("R8 other rank rd", int'(qry_wait), 0);
        chk("R8 other rank act", int'(qry_act_wait), 0);
    endtask

    task automatic t_same_cycle();
        drain();
        set_col(0, 1, 0);
        act_valid = 1; act_rank = 1; act_bank = 5;
        wake_valid = 1; wake_rank = 1; wake_exit = 5;
        @(negedge clk);
        col_valid = 0; act_valid = 0; wake_valid = 0;
        peek(1, 1, 1);
        chk("R10 col wins wr", int'(qry_wait), 7);
        peek(0, 1, 5);
        chk("R10 act wins rd", int'(qry_wait), 9);
        chk("R10 wake wins act", int'(qry_act_wait), 4);
        chk("R10 act wins pre", int'(qry_pre_wait), 19);
        peek(0, 1, 4);
        chk("R10 wake over burst", int'(qry_wait), 4);
        peek(0, 0, 0);
        chk("R10 other rank", int'(qry_wait), 5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_gaps();
        t_ready();
        t_no_early();
        t_activate();
        t_wake();
        t_same_cycle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog got=hung exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule